// File: doc/BRIEF.md
# Dual-Result Prefix Adder for Mantissa Rounding

This block adds two unsigned operands and returns, in one combinational pass, both the plain sum and the sum incremented by one, each with its own carry-out. A floating-point mantissa datapath can then choose the rounded or the unrounded result with a late multiplexer. It does not need a second addition after the rounding decision.

Carries are formed by a logarithmic parallel-prefix tree. The number of levels is the ceiling of log2 of the operand width, and the span doubles at each level. Every node of the tree is a full (black) cell. Each node therefore holds both the group generate and the group propagate of the range from its bit down to bit 0. Without the propagate terms, the incremented sum would need a second carry chain. With them, each incremented bit is one XOR away from the plain sum bit. The block has no clock, no state and no state machine. Its single operating condition is "inputs applied, outputs settled".

Top module: `cpa_compound_adder`

## Requirements
- R1: `sum_o` equals (`a_i` + `b_i`) modulo 2^WIDTH.
- R2: `cout_o` equals bit WIDTH of the full-precision value `a_i` + `b_i`.
- R3: `sum_inc_o` equals (`a_i` + `b_i` + 1) modulo 2^WIDTH.
- R4: `cout_inc_o` equals bit WIDTH of `a_i` + `b_i` + 1, so `cout_inc_o` is 1 whenever `cout_o` is 1.
- R5: With both operands all ones (0xFFFFFF at WIDTH=24), `sum_o` is 0xFFFFFE, `sum_inc_o` is 0xFFFFFF, and both carries are 1.
- R6: When the sum is all ones with no carry (for example, 0xFFFFFF + 0), `sum_o` is 0xFFFFFF with `cout_o` 0, and `sum_inc_o` is 0 with `cout_inc_o` 1. The increment ripples through every bit position.
- R7: With both operands zero, `sum_o` is 0, `sum_inc_o` is 1, and both carries are 0.
- R8: The outputs are a pure function of the present inputs. A new operand pair is reflected on every output without any clock edge, and earlier operands leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| sum_o | output | WIDTH | Low WIDTH bits of a_i + b_i |
| sum_inc_o | output | WIDTH | Low WIDTH bits of a_i + b_i + 1 |
| cout_o | output | 1 | Carry-out of a_i + b_i |
| cout_inc_o | output | 1 | Carry-out of a_i + b_i + 1 |

## Verification
The bench builds the adder at its default WIDTH of 24, which gives five prefix levels with spans 1, 2, 4, 8 and 16. Carries that cross 16 or more positions exercise the last level. The bench uses vectors built to produce such carries: all-ones sums, a single generate at bit 0 feeding a long propagate run, and a carry that first appears at bit 23. It also runs random operand pairs and compares both result pairs against full-precision reference additions.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

    localparam int CPA_DEFAULT_WIDTH = 24;

    // prefix levels needed so the widest span reaches bit 0 from the MSB
    function automatic int cpa_levels(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/cpa_bit_terms.sv
module cpa_bit_terms #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);

    genvar bit_idx;
    for (bit_idx = 0; bit_idx < WIDTH; bit_idx++) begin : g_term
        assign gen_o[bit_idx]  = a_i[bit_idx] & b_i[bit_idx];
        assign prop_o[bit_idx] = a_i[bit_idx] ^ b_i[bit_idx];
    end

endmodule

// File: rtl/cpa_prefix_tree.sv
module cpa_prefix_tree #(
    parameter int WIDTH  = 24,
    parameter int LEVELS = 5
) (
    input  logic [WIDTH-1:0] gen_i,
    input  logic [WIDTH-1:0] prop_i,
    output logic [WIDTH-1:0] grp_gen_o,
    output logic [WIDTH-1:0] grp_prop_o
);

    genvar lvl, pos;
    for (lvl = 0; lvl < LEVELS; lvl++) begin : g_stage
        localparam int SPAN = 1 << lvl;
        logic [WIDTH-1:0] g_in, p_in, g_out, p_out;

        if (lvl == 0) begin : g_head
            assign g_in = gen_i;
            assign p_in = prop_i;
        end else begin : g_link
            assign g_in = g_stage[lvl-1].g_out;
            assign p_in = g_stage[lvl-1].p_out;
        end

        for (pos = 0; pos < WIDTH; pos++) begin : g_node
            if (pos >= SPAN) begin : g_black
                assign g_out[pos] = g_in[pos] | (p_in[pos] & g_in[pos-SPAN]);
                assign p_out[pos] = p_in[pos] & p_in[pos-SPAN];
            end else begin : g_pass
                assign g_out[pos] = g_in[pos];
                assign p_out[pos] = p_in[pos];
            end
        end
    end

    assign grp_gen_o  = g_stage[LEVELS-1].g_out;
    assign grp_prop_o = g_stage[LEVELS-1].p_out;

    // R3: a group cannot both generate and propagate; this lets the
    // incremented carry be formed with XOR instead of OR
    always_comb begin
        if (!$isunknown({grp_gen_o, grp_prop_o}))
            a_r3_gp_exclusive: assert ((grp_gen_o & grp_prop_o) == '0)
                else $error("group generate and propagate overlap");
    end

endmodule

// File: rtl/cpa_sum_pair.sv
module cpa_sum_pair #(
    parameter int WIDTH = 24
) (
    input  logic [WIDTH-1:0] prop_i,
    input  logic [WIDTH-1:0] grp_gen_i,
    input  logic [WIDTH-1:0] grp_prop_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] sum_inc_o,
    output logic             cout_o,
    output logic             cout_inc_o
);

    // carry into each bit from the range below it; empty range below bit 0
    logic [WIDTH-1:0] carry_in;
    logic [WIDTH-1:0] all_prop_below;

    assign carry_in       = {grp_gen_i[WIDTH-2:0], 1'b0};
    assign all_prop_below = {grp_prop_i[WIDTH-2:0], 1'b1};

    assign sum_o      = prop_i ^ carry_in;
    assign sum_inc_o  = sum_o ^ all_prop_below;
    assign cout_o     = grp_gen_i[WIDTH-1];
    assign cout_inc_o = grp_gen_i[WIDTH-1] | grp_prop_i[WIDTH-1];

    always_comb begin
        if (!$isunknown({prop_i, grp_gen_i, grp_prop_i})) begin
            // R3 and R4: the incremented pair is the plain pair plus one
            a_r3_inc_by_one: assert ({cout_inc_o, sum_inc_o} ==
                                     ({1'b0, cout_o, sum_o} + 1'b1))
                else $error("incremented result is not sum plus one");
            // R4: the increment can only add a carry, never remove one
            a_r4_cout_order: assert (!cout_o || cout_inc_o)
                else $error("carry lost by increment");
        end
    end

endmodule

// File: rtl/cpa_compound_adder.sv
module cpa_compound_adder
    import cpa_pkg::*;
#(
    parameter int WIDTH = CPA_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] sum_inc_o,
    output logic             cout_o,
    output logic             cout_inc_o
);

    localparam int LEVELS = cpa_levels(WIDTH);

    logic [WIDTH-1:0] bit_gen, bit_prop;
    logic [WIDTH-1:0] grp_gen, grp_prop;

    cpa_bit_terms #(.WIDTH(WIDTH)) u_terms (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    cpa_prefix_tree #(.WIDTH(WIDTH), .LEVELS(LEVELS)) u_tree (
        .gen_i      (bit_gen),
        .prop_i     (bit_prop),
        .grp_gen_o  (grp_gen),
        .grp_prop_o (grp_prop)
    );

    cpa_sum_pair #(.WIDTH(WIDTH)) u_pair (
        .prop_i     (bit_prop),
        .grp_gen_i  (grp_gen),
        .grp_prop_i (grp_prop),
        .sum_o      (sum_o),
        .sum_inc_o  (sum_inc_o),
        .cout_o     (cout_o),
        .cout_inc_o (cout_inc_o)
    );

    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            // R1 and R2: plain pair matches full-precision addition
            a_r1_sum_exact: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
                else $error("sum mismatch");
            // R7: zero operands give zero sum and carry-free increment
            if (a_i == '0 && b_i == '0)
                a_r7_zero_case: assert (sum_o == '0 && !cout_o && !cout_inc_o)
                    else $error("zero operand case wrong");
        end
    end

endmodule

// File: tb/tb_cpa_compound_adder.sv
module tb_cpa_compound_adder;

    localparam int W = 24;
    localparam logic [W-1:0] ONES = '1;

    logic clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    logic [W-1:0] a, b, sum, sum_inc;
    logic         cout, cout_inc;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    cpa_compound_adder #(.WIDTH(W)) dut (
        .a_i(a), .b_i(b), .sum_o(sum), .sum_inc_o(sum_inc),
        .cout_o(cout), .cout_inc_o(cout_inc)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (a=%h b=%h)", req, got, exp, a, b);
        end
    endtask

    // apply at a rising edge, sample at the following falling edge
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        a = x;
        b = y;
        @(negedge clk);
    endtask

    task automatic check_ref(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W:0] ref_sum, ref_inc;
        apply(x, y);
        ref_sum = {1'b0, x} + {1'b0, y};
        ref_inc = ref_sum + 1'b1;
        check("R1", {1'b0, sum}, {1'b0, ref_sum[W-1:0]});
        check("R2", {{W{1'b0}}, cout}, {{W{1'b0}}, ref_sum[W]});
        check("R3", {1'b0, sum_inc}, {1'b0, ref_inc[W-1:0]});
        check("R4", {{W{1'b0}}, cout_inc}, {{W{1'b0}}, ref_inc[W]});
    endtask

    task automatic t_zero();  // R7
        apply('0, '0);
        check("R7", {cout, sum}, '0);
        check("R7", {cout_inc, sum_inc}, {1'b0, {(W-1){1'b0}}, 1'b1});
    endtask

    task automatic t_all_ones();  // R5
        apply(ONES, ONES);
        check("R5", {cout, sum}, {1'b1, ONES[W-1:1], 1'b0});
        check("R5", {cout_inc, sum_inc}, {1'b1, ONES});
    endtask

    task automatic t_full_ripple();  // R6
        apply(ONES, '0);
        check("R6", {cout, sum}, {1'b0, ONES});
        check("R6", {cout_inc, sum_inc}, {1'b1, {W{1'b0}}});
        apply(24'hAAAAAA, 24'h555555);
        check("R6", {cout, sum}, {1'b0, ONES});
        check("R6", {cout_inc, sum_inc}, {1'b1, {W{1'b0}}});
    endtask

    task automatic t_long_carries();  // R1-style reference checks on span-16 paths
        check_ref(24'h000001, 24'hFFFFFF);  // generate at 0 across all bits
        check_ref(24'h800000, 24'h800000);  // carry born at MSB
        check_ref(24'h7FFFFF, 24'h000001);
        check_ref(24'h0FFFFF, 24'hF00001);
        check_ref(24'h123456, 24'hEDCBA9);
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++)
            check_ref(W'($urandom), W'($urandom));
    endtask

    task automatic t_no_memory();  // R8
        apply(ONES, ONES);
        a = 24'h000003;
        b = 24'h000004;
        #1;  // no clock edge in between
        check("R8", {cout, sum}, {1'b0, 24'h000007});
        check("R8", {cout_inc, sum_inc}, {1'b0, 24'h000008});
    endtask

    initial begin
        a = '0;
        b = '0;
        @(negedge clk);
        check("R7", {cout, sum}, '0);  // initial state
        t_zero();
        t_all_ones();
        t_full_ripple();
        t_long_carries();
        t_no_memory();
        t_random();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule